// File: doc/BRIEF.md
# Cluster Hub Receive Dispatcher

This block sits on the receive side of a cluster hub attached to a shared broadcast medium. Every sending hub owns a private channel on that medium, so flits from many senders can land in the same clock cycle; the dispatcher gives each sender a FIFO of its own and writes every arriving flit into it. No arbitration is needed at the input.

On the output side the block drives two intra-cluster broadcast trees. A flit's tree is fixed by the parity of the sender's cluster number. Among the FIFOs that feed one tree, a round-robin arbiter takes at most one flit per cycle. Unicast flits addressed to a core in another cluster are discarded before they reach a FIFO. Each outgoing flit carries a 16-bit core delivery mask. The block tells each sender to pause once that sender's FIFO no longer has room for the flits that may already be in flight on the medium.

Top module: `hub_rx_dispatch`

## Requirements
- R1: While reset is high and in the first cycle after it, no tree output is valid and no stop bit is set.
- R2: Flits from several senders that arrive in the same cycle are all kept and all leave the block.
- R3: A flit from an even-numbered sender leaves on tree 0 and a flit from an odd-numbered sender leaves on tree 1.
- R4: Each tree issues at most one flit per cycle. Among senders of the same parity, service is round-robin, starting from the lowest-numbered sender after reset.
- R5: Flits from one sender leave in the order in which they arrived.
- R6: A unicast flit (broadcast bit 0) whose destination cluster field, bits [9:4] of the 10-bit destination, differs from `my_cluster` is dropped and never appears at an output.
- R7: The delivery mask is all ones for a broadcast flit. For a kept unicast flit it has only bit c set, where c is the destination core field, bits [3:0].
- R8: An outgoing flit carries the sender number, broadcast bit, destination, type, tag and 128-bit data unchanged.
- R9: A sender's stop bit is high exactly when its FIFO holds fewer free slots than `RTT`.
- R10: A flit that arrives while its sender's FIFO is full, judged on the occupancy before that clock edge, is discarded.
- R11: A flit presented before clock edge k to an empty FIFO whose tree is idle is valid at the output after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| my_cluster | input | 6 | Number of this hub's cluster |
| in_valid | input | N_SEND | Per-sender flit valid |
| in_bcast | input | N_SEND | Per-sender broadcast bit |
| in_dst | input | N_SEND*10 | Per-sender destination {cluster, core} |
| in_type | input | N_SEND*3 | Per-sender message type |
| in_tag | input | N_SEND*4 | Per-sender message tag |
| in_data | input | N_SEND*128 | Per-sender payload |
| stop_out | output | N_SEND | Per-sender backward flow-control stop |
| out_valid | output | 2 | Tree flit valid |
| out_src | output | 12 | Sender number per tree |
| out_bcast | output | 2 | Broadcast bit per tree |
| out_dst | output | 20 | Destination per tree |
| out_type | output | 6 | Message type per tree |
| out_tag | output | 8 | Message tag per tree |
| out_data | output | 256 | Payload per tree |
| out_mask | output | 32 | Core delivery mask per tree |

## Verification
The bench loads three same-parity senders and one odd sender in the same cycle. A design that shared one FIFO, or arbitrated across both trees, would lose or delay flits, and a design with a wrong round-robin start would emit 2 before 0. Two even senders are flooded for twenty cycles. This catches a stop threshold off by one slot, a FIFO that overwrites its oldest entry when full, and a design that reorders one sender's flits. Unicast flits are sent both to this cluster and to others. A missing filter shows up as extra output flits, and a mask built from the wrong bits lights the wrong core.

// File: rtl/hub_rx_pkg.sv
package hub_rx_pkg;

    localparam int DATA_W = 128;
    localparam int CLUS_W = 6;
    localparam int CORE_W = 4;
    localparam int TYPE_W = 3;
    localparam int TAG_W  = 4;
    localparam int DST_W  = CLUS_W + CORE_W;
    localparam int CORES  = 1 << CORE_W;

    typedef struct packed {
        logic              bcast;
        logic [DST_W-1:0]  dst;
        logic [TYPE_W-1:0] mtype;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } ent_t;

    localparam int ENT_W = $bits(ent_t);

    typedef struct packed {
        logic [CLUS_W-1:0] src;
        ent_t              body;
        logic [CORES-1:0]  mask;
    } oflit_t;

    function automatic logic [CLUS_W-1:0] dst_cluster(input logic [DST_W-1:0] d);
        return d[DST_W-1 -: CLUS_W];
    endfunction

    function automatic logic [CORES-1:0] fan_mask(input logic bc, input logic [DST_W-1:0] d);
        if (bc) return '1;
        return CORES'(1) << d[CORE_W-1:0];
    endfunction

    function automatic logic keep_flit(input logic bc, input logic [DST_W-1:0] d,
                                       input logic [CLUS_W-1:0] here);
        return bc || (dst_cluster(d) == here);
    endfunction

endpackage

// File: rtl/hub_rx_fifo.sv
module hub_rx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [W-1:0]               wr_data,
    input  logic                       rd_en,
    output logic [W-1:0]               rd_data,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_wr, do_rd;

    assign do_wr   = wr_en && (count < CW'(DEPTH));
    assign do_rd   = rd_en && (count != '0);
    assign empty   = (count == '0);
    assign rd_data = mem[rp];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_wr) wp <= bump(wp);
            if (do_rd) rp <= bump(rp);
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/hub_rx_rr_arb.sv
module hub_rx_rr_arb #(
    parameter int M = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [M-1:0]         req,
    output logic                 gnt_valid,
    output logic [$clog2(M)-1:0] gnt_idx
);
    localparam int IW = $clog2(M);

    logic [IW-1:0] last;

    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int i = 0; i < M; i++) begin
            int c;
            c = int'(last) + 1 + i;
            if (c >= M) c = c - M;
            if (!gnt_valid && req[IW'(c)]) begin
                gnt_valid = 1'b1;
                gnt_idx   = IW'(c);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            last <= IW'(M - 1);
        else if (gnt_valid) last <= gnt_idx;
    end
endmodule

// File: rtl/hub_rx_dispatch.sv
module hub_rx_dispatch
    import hub_rx_pkg::*;
#(
    parameter int N_SEND = 64,
    parameter int DEPTH  = 8,
    parameter int RTT    = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [CLUS_W-1:0]          my_cluster,
    input  logic [N_SEND-1:0]          in_valid,
    input  logic [N_SEND-1:0]          in_bcast,
    input  logic [N_SEND*DST_W-1:0]    in_dst,
    input  logic [N_SEND*TYPE_W-1:0]   in_type,
    input  logic [N_SEND*TAG_W-1:0]    in_tag,
    input  logic [N_SEND*DATA_W-1:0]   in_data,
    output logic [N_SEND-1:0]          stop_out,
    output logic [1:0]                 out_valid,
    output logic [2*CLUS_W-1:0]        out_src,
    output logic [1:0]                 out_bcast,
    output logic [2*DST_W-1:0]         out_dst,
    output logic [2*TYPE_W-1:0]        out_type,
    output logic [2*TAG_W-1:0]         out_tag,
    output logic [2*DATA_W-1:0]        out_data,
    output logic [2*CORES-1:0]         out_mask
);
    localparam int M  = N_SEND / 2;
    localparam int IW = $clog2(M);
    localparam int CW = $clog2(DEPTH + 1);

    logic [N_SEND-1:0] empty;
    logic [N_SEND-1:0] rd_en;
    ent_t              head [N_SEND];
    logic [CW-1:0]     cnt  [N_SEND];
    logic [1:0]        gv;
    logic [IW-1:0]     gi   [2];

    // one FIFO per sender; the filter sits ahead of the write port
    for (genvar s = 0; s < N_SEND; s++) begin : g_snd
        ent_t in_ent;
        logic keep;
        assign in_ent.bcast = in_bcast[s];
        assign in_ent.dst   = in_dst [s*DST_W  +: DST_W];
        assign in_ent.mtype = in_type[s*TYPE_W +: TYPE_W];
        assign in_ent.tag   = in_tag [s*TAG_W  +: TAG_W];
        assign in_ent.data  = in_data[s*DATA_W +: DATA_W];
        assign keep = in_valid[s] && keep_flit(in_ent.bcast, in_ent.dst, my_cluster);

        hub_rx_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_q (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (keep),
            .wr_data (in_ent),
            .rd_en   (rd_en[s]),
            .rd_data (head[s]),
            .empty   (empty[s]),
            .count   (cnt[s])
        );

        assign rd_en[s]    = gv[s % 2] && (gi[s % 2] == IW'(s / 2));
        assign stop_out[s] = (DEPTH - int'(cnt[s])) < RTT;
    end

    // two trees, chosen by sender parity
    for (genvar t = 0; t < 2; t++) begin : g_tree
        logic [M-1:0] req;
        oflit_t       q;
        logic         qv;
        logic [IW:0]  sel;

        for (genvar i = 0; i < M; i++) begin : g_req
            assign req[i] = ~empty[2*i + t];
        end

        hub_rx_rr_arb #(.M(M)) u_arb (
            .clk       (clk),
            .rst       (rst),
            .req       (req),
            .gnt_valid (gv[t]),
            .gnt_idx   (gi[t])
        );

        assign sel = {gi[t], 1'(t)};

        always_ff @(posedge clk) begin
            if (rst) begin
                qv <= 1'b0;
            end else begin
                qv <= gv[t];
                if (gv[t]) begin
                    q.src  <= CLUS_W'(sel);
                    q.body <= head[sel];
                    q.mask <= fan_mask(head[sel].bcast, head[sel].dst);
                end
            end
        end

        assign out_valid[t]                  = qv;
        assign out_src  [t*CLUS_W +: CLUS_W] = q.src;
        assign out_bcast[t]                  = q.body.bcast;
        assign out_dst  [t*DST_W  +: DST_W]  = q.body.dst;
        assign out_type [t*TYPE_W +: TYPE_W] = q.body.mtype;
        assign out_tag  [t*TAG_W  +: TAG_W]  = q.body.tag;
        assign out_data [t*DATA_W +: DATA_W] = q.body.data;
        assign out_mask [t*CORES  +: CORES]  = q.mask;
    end
endmodule

// File: rtl/hub_rx_dispatch_chk.sv
module hub_rx_dispatch_chk
    import hub_rx_pkg::*;
#(
    parameter int N_SEND = 64
) (
    input logic                clk,
    input logic                rst,
    input logic [CLUS_W-1:0]   my_cluster,
    input logic [N_SEND-1:0]   stop_out,
    input logic [1:0]          out_valid,
    input logic [2*CLUS_W-1:0] out_src,
    input logic [1:0]          out_bcast,
    input logic [2*DST_W-1:0]  out_dst,
    input logic [2*CORES-1:0]  out_mask
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (out_valid == 2'b00 && stop_out == '0)); // R1

    for (genvar t = 0; t < 2; t++) begin : g_t
        AST_TREE_PARITY: assert property (@(posedge clk) disable iff (rst)
            out_valid[t] |-> (out_src[t*CLUS_W] == 1'(t))); // R3

        AST_UNICAST_LOCAL: assert property (@(posedge clk) disable iff (rst)
            (out_valid[t] && !out_bcast[t]) |->
            (out_dst[t*DST_W + CORE_W +: CLUS_W] == my_cluster)); // R6

        AST_UNICAST_ONE_CORE: assert property (@(posedge clk) disable iff (rst)
            (out_valid[t] && !out_bcast[t]) |->
            ($countones(out_mask[t*CORES +: CORES]) == 1)); // R7

        AST_BCAST_ALL_CORES: assert property (@(posedge clk) disable iff (rst)
            (out_valid[t] && out_bcast[t]) |->
            (out_mask[t*CORES +: CORES] == '1)); // R7
    end
endmodule

bind hub_rx_dispatch hub_rx_dispatch_chk #(.N_SEND(N_SEND)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .my_cluster (my_cluster),
    .stop_out   (stop_out),
    .out_valid  (out_valid),
    .out_src    (out_src),
    .out_bcast  (out_bcast),
    .out_dst    (out_dst),
    .out_mask   (out_mask)
);

// File: tb/tb_hub_rx_dispatch.sv
module tb_hub_rx_dispatch;
    import hub_rx_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NS   = 64;
    localparam int HERE = 5;

    logic                    clk = 0;
    logic                    rst = 1;
    logic [CLUS_W-1:0]       my_cluster = CLUS_W'(HERE);
    logic [NS-1:0]           in_valid = '0;
    logic [NS-1:0]           in_bcast = '0;
    logic [NS*DST_W-1:0]     in_dst   = '0;
    logic [NS*TYPE_W-1:0]    in_type  = '0;
    logic [NS*TAG_W-1:0]     in_tag   = '0;
    logic [NS*DATA_W-1:0]    in_data  = '0;
    logic [NS-1:0]           stop_out;
    logic [1:0]              out_valid;
    logic [2*CLUS_W-1:0]     out_src;
    logic [1:0]              out_bcast;
    logic [2*DST_W-1:0]      out_dst;
    logic [2*TYPE_W-1:0]     out_type;
    logic [2*TAG_W-1:0]      out_tag;
    logic [2*DATA_W-1:0]     out_data;
    logic [2*CORES-1:0]      out_mask;

    int n_chk = 0;
    int n_fail = 0;

    hub_rx_dispatch #(.N_SEND(NS), .DEPTH(8), .RTT(3)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [5:0]       snd;
        logic             bc;
        logic [DST_W-1:0] dst;
        logic             deliver;
        logic [CORES-1:0] mask;
    } vec_t;

    // sender, broadcast, {cluster,core}, delivered, expected mask
    localparam vec_t VECS [7] = '{
        '{6'd0,  1'b1, {6'd9, 4'd2},  1'b1, 16'hFFFF},
        '{6'd1,  1'b1, {6'd0, 4'd0},  1'b1, 16'hFFFF},
        '{6'd7,  1'b0, {6'd5, 4'd3},  1'b1, 16'h0008},
        '{6'd8,  1'b0, {6'd6, 4'd3},  1'b0, 16'h0000},
        '{6'd63, 1'b0, {6'd5, 4'd15}, 1'b1, 16'h8000},
        '{6'd62, 1'b0, {6'd0, 4'd0},  1'b0, 16'h0000},
        '{6'd10, 1'b1, {6'd4, 4'd1},  1'b1, 16'hFFFF}
    };

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input int s, input logic bc, input logic [DST_W-1:0] d,
                       input logic [TYPE_W-1:0] ty, input logic [TAG_W-1:0] tg,
                       input logic [DATA_W-1:0] dat);
        in_valid[s]                 = 1'b1;
        in_bcast[s]                 = bc;
        in_dst [s*DST_W  +: DST_W]  = d;
        in_type[s*TYPE_W +: TYPE_W] = ty;
        in_tag [s*TAG_W  +: TAG_W]  = tg;
        in_data[s*DATA_W +: DATA_W] = dat;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        chk("R1 valid", 128'(out_valid), 128'd0);
        chk("R1 stop", 128'(stop_out), 128'd0);

        // table walk: one flit per vector
        for (int i = 0; i < 7; i++) begin
            vec_t v;
            int t;
            v = VECS[i];
            t = int'(v.snd[0]);
            put(int'(v.snd), v.bc, v.dst, TYPE_W'(i), TAG_W'(i + 3), {4{32'hC0DE_0000 + 32'(i)}});
            @(negedge clk);
            in_valid = '0;
            @(negedge clk);
            chk($sformatf("R11/R6 v%0d valid", i), 128'(out_valid[t]), 128'(v.deliver));
            chk($sformatf("R3 v%0d other tree idle", i), 128'(out_valid[1-t]), 128'd0);
            if (v.deliver) begin
                chk($sformatf("R8 v%0d src", i), 128'(out_src[t*CLUS_W +: CLUS_W]), 128'(v.snd));
                chk($sformatf("R8 v%0d dst", i), 128'(out_dst[t*DST_W +: DST_W]), 128'(v.dst));
                chk($sformatf("R8 v%0d type/tag", i),
                    128'({out_type[t*TYPE_W +: TYPE_W], out_tag[t*TAG_W +: TAG_W]}),
                    128'({TYPE_W'(i), TAG_W'(i + 3)}));
                chk($sformatf("R8 v%0d data", i), out_data[t*DATA_W +: DATA_W],
                    {4{32'hC0DE_0000 + 32'(i)}});
                chk($sformatf("R7 v%0d mask", i), 128'(out_mask[t*CORES +: CORES]), 128'(v.mask));
            end
            @(negedge clk);
            chk($sformatf("R6 v%0d no late flit", i), 128'(out_valid), 128'd0);
        end

        // same-cycle arrivals on both parities
        do_reset();
        put(0, 1'b1, '0, '0, '0, 128'h100);
        put(2, 1'b1, '0, '0, '0, 128'h102);
        put(4, 1'b1, '0, '0, '0, 128'h104);
        put(1, 1'b1, '0, '0, '0, 128'h101);
        @(negedge clk);
        in_valid = '0;
        @(negedge clk);
        chk("R4 first pick tree0", 128'({out_valid[0], out_src[5:0]}), 128'({1'b1, 6'd0}));
        chk("R2 odd sender tree1", 128'({out_valid[1], out_src[11:6]}), 128'({1'b1, 6'd1}));
        @(negedge clk);
        chk("R4 second pick tree0", 128'({out_valid[0], out_src[5:0]}), 128'({1'b1, 6'd2}));
        chk("R4 tree1 drained", 128'(out_valid[1]), 128'd0);
        @(negedge clk);
        chk("R2 third pick tree0", 128'({out_valid[0], out_src[5:0]}), 128'({1'b1, 6'd4}));
        @(negedge clk);
        chk("R4 tree0 drained", 128'(out_valid), 128'd0);

        // flood senders 0 and 2 for 20 cycles
        do_reset();
        begin
            int got0, got2, last0, last2, bad_order;
            got0 = 0; got2 = 0; last0 = 0; last2 = 0; bad_order = 0;
            for (int cyc = 1; cyc <= 60; cyc++) begin
                if (cyc <= 20) begin
                    put(0, 1'b1, '0, '0, '0, 128'(cyc));
                    put(2, 1'b1, '0, '0, '0, 128'(cyc));
                end else begin
                    in_valid = '0;
                end
                @(negedge clk);
                if (out_valid[1]) bad_order++;
                if (out_valid[0]) begin
                    if (out_src[5:0] == 6'd0) begin
                        if (int'(out_data[31:0]) <= last0) bad_order++;
                        last0 = int'(out_data[31:0]);
                        got0++;
                    end else if (out_src[5:0] == 6'd2) begin
                        if (int'(out_data[31:0]) <= last2) bad_order++;
                        last2 = int'(out_data[31:0]);
                        got2++;
                    end else begin
                        bad_order++;
                    end
                end
                if (cyc == 10) begin
                    chk("R9 stop sender2 at 6 used", 128'(stop_out[2]), 128'd1);
                    chk("R9 no stop sender0 at 5 used", 128'(stop_out[0]), 128'd0);
                end
                if (cyc == 11)
                    chk("R9 stop sender0 at 6 used", 128'(stop_out[0]), 128'd1);
            end
            chk("R10 sender0 delivered", 128'(got0), 128'd17);
            chk("R10 sender2 delivered", 128'(got2), 128'd17);
            chk("R5 order kept", 128'(bad_order), 128'd0);
            chk("R9 stop released", 128'(stop_out), 128'd0);
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule